// File: doc/BRIEF.md
# Command Runout Log and Interrupt Collector

This block keeps a circular log of command-submission attempts that an upstream pusher refused. Each refused attempt arrives as a single strobe carrying a 64-bit record (an address word and a data word). When the log has a free slot, the record is stored and a runout event is flagged. When the log has no free slot, the record is dropped and a separate overflow event is flagged instead. Software drains the log by reading the record at the read pointer and then advancing that pointer through a register write.

The same block collects three other event strobes: a puller fault, a malformed DMA command stream and a DMA page fault. Every event sets a sticky pending bit. A pending bit stays set until software writes 1 to it. An enable mask decides which pending bits can drive the single registered interrupt line. A global enable input acts as a master switch. While it is low, the mask register and a channel-switch enable register are held at zero. Pending bits still latch while it is low.

The register bus is a single-cycle write strobe with a 3-bit word address. Read data is combinational from the address.

Top module: `runout_irq_unit`

## Requirements
- R1: After a synchronous reset, the following all read 0: read pointer, write pointer, pending, mask and channel-switch enable. The irq output is 0, log_empty is 1 and log_full is 0.
- R2: A reject strobe while the log is not full stores the 64-bit record at the write pointer. The write pointer then advances by one, modulo LOG_DEPTH. Pending bit 4 (runout) is set on the next cycle.
- R3: The log is full when the write pointer plus one, modulo LOG_DEPTH, equals the read pointer. A reject strobe while full stores nothing and leaves the write pointer unchanged. It sets pending bit 8 (overflow) instead of bit 4.
- R4: The event strobes set their pending bits on the next cycle: puller fault sets bit 0, malformed DMA stream sets bit 12 and DMA page fault sets bit 16. Pending bits are set whatever the mask holds.
- R5: A write to the pending register (address 3) clears every bit written as 1 and leaves bits written as 0 unchanged. If an event sets a bit in the same cycle as a write clears it, the bit ends up set.
- R6: The mask register (address 4) keeps only bits 0, 4, 8, 12 and 16, with 1 meaning enabled. The irq output is a register. It takes the OR of (pending AND mask) as those registers stood one cycle earlier.
- R7: A write to address 2 sets the read pointer to the written value modulo LOG_DEPTH. Addresses 6 and 7 return the low and high 32 bits of the record at the read pointer.
- R8: Address 0 reads bit 0 = empty (pointers equal) and bit 1 = full. The log_empty and log_full outputs show the same two flags. Address 1 reads the write pointer.
- R9: While glob_en is low, the mask register and the channel-switch enable (address 5, bit 0, also shown on chsw_en) are forced to 0 at each clock edge. Writes to them have no effect while glob_en is low.
- R10: The word addresses are fixed: 0 status, 1 write pointer, 2 read pointer, 3 pending, 4 mask, 5 channel-switch enable, 6 record low, 7 record high. Writes to addresses 0, 1, 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glob_en | input | 1 | Global enable; low holds mask and channel-switch enable at zero |
| rej_valid | input | 1 | A submission was refused this cycle |
| rej_entry | input | 64 | Refused record: [63:32] data, [31:0] address |
| ev_pull_err | input | 1 | Puller fault event |
| ev_dma_bad | input | 1 | Malformed DMA command stream event |
| ev_dma_fault | input | 1 | DMA page fault event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Registered interrupt line |
| chsw_en | output | 1 | Channel-switch enable register bit |
| log_full | output | 1 | Log has no free slot |
| log_empty | output | 1 | Log holds no record |

## Verification
Two functions can fall in the same cycle. First, an event can set a pending bit in the same cycle as a write clears it. Second, a reject can arrive in the same cycle as the read pointer is rewritten, so the full test and the pointer update meet. The bench makes both happen with directed cycles: a puller fault together with a clear of bit 0, and a burst of rejects that fills the log. It then runs a long stretch of random strobes and random writes to every address, with glob_en toggling, so these collisions recur many times. A behavioural reference model updates on every clock and is compared against every output and the selected read word. The result is judged on the rule that a set beats a clear, and that fullness is decided from the pointers as they stood before the edge.

// File: rtl/runout_pkg.sv
package runout_pkg;

    localparam int REG_AW   = 3;
    localparam int DATA_W   = 32;

    // pending / mask bit positions
    localparam int IRQ_PULL_ERR  = 0;
    localparam int IRQ_RUNOUT    = 4;
    localparam int IRQ_OVERFLOW  = 8;
    localparam int IRQ_DMA_BAD   = 12;
    localparam int IRQ_DMA_FAULT = 16;

    localparam logic [DATA_W-1:0] IRQ_VALID =
        (32'd1 << IRQ_PULL_ERR) | (32'd1 << IRQ_RUNOUT) | (32'd1 << IRQ_OVERFLOW) |
        (32'd1 << IRQ_DMA_BAD)  | (32'd1 << IRQ_DMA_FAULT);

    typedef enum logic [REG_AW-1:0] {
        SEL_STATUS = 3'd0,
        SEL_PUT    = 3'd1,
        SEL_GET    = 3'd2,
        SEL_PEND   = 3'd3,
        SEL_MASK   = 3'd4,
        SEL_SWITCH = 3'd5,
        SEL_HEAD_L = 3'd6,
        SEL_HEAD_H = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [31:0] data;
        logic [31:0] addr;
    } runout_rec_t;

endpackage

// File: rtl/runout_ring.sv
module runout_ring
    import runout_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  runout_rec_t   rec_i,
    input  logic          get_wr_i,
    input  logic [PW-1:0] get_val_i,
    output logic [PW-1:0] put_o,
    output logic [PW-1:0] get_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          accept_o,
    output logic          drop_o,
    output runout_rec_t   head_o
);

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    runout_rec_t   store [DEPTH];
    logic [PW-1:0] put_q, get_q, put_inc;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign put_inc  = bump(put_q);
    assign full_o   = (put_inc == get_q);
    assign empty_o  = (put_q == get_q);
    assign accept_o = push_i && !full_o;
    assign drop_o   = push_i && full_o;
    assign put_o    = put_q;
    assign get_o    = get_q;
    assign head_o   = store[get_q];

    always_ff @(posedge clk) begin
        if (accept_o) store[put_q] <= rec_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            put_q <= '0;
            get_q <= '0;
        end else begin
            if (accept_o) put_q <= put_inc;
            if (get_wr_i) get_q <= get_val_i;
        end
    end

    // a refused record while full must not move the write pointer
    assert_full_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (push_i && full_o) |=> $stable(put_q));

    // an accepted record advances the write pointer by one with wrap
    assert_put_step_R2: assert property (@(posedge clk) disable iff (rst)
        (push_i && !full_o) |=> (put_q == (($past(put_q) == LAST) ? '0 : $past(put_q) + 1'b1)));

    // without a reject the write pointer never moves
    assert_put_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !push_i |=> $stable(put_q));

endmodule

// File: rtl/runout_irq.sv
module runout_irq
    import runout_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [DATA_W-1:0] set_i,
    input  logic [DATA_W-1:0] clr_i,
    input  logic              mask_wr_i,
    input  logic [DATA_W-1:0] mask_val_i,
    output logic [DATA_W-1:0] pend_o,
    output logic [DATA_W-1:0] mask_o,
    output logic              irq_o
);

    logic [DATA_W-1:0] pend_q, mask_q;
    logic              irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            pend_q <= ((pend_q & ~clr_i) | set_i) & IRQ_VALID;
            irq_q  <= |(pend_q & mask_q);
            if (!en_i)          mask_q <= '0;
            else if (mask_wr_i) mask_q <= mask_val_i & IRQ_VALID;
        end
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;
    assign irq_o  = irq_q;

    // a pending bit only drops when software wrote 1 to it
    assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(pend_q) & ~pend_q) & ~$past(clr_i)) == '0));

    // a fresh event is always visible one cycle later
    assert_set_seen_R4: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));

    // the line is only raised by an enabled pending source
    assert_irq_source_R6: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> ($past(pend_q & mask_q) != '0));

    // master switch low leaves the mask cleared
    assert_mask_forced_R9: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (mask_q == '0));

endmodule

// File: rtl/runout_irq_unit.sv
module runout_irq_unit
    import runout_pkg::*;
#(
    parameter int LOG_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        glob_en,
    input  logic        rej_valid,
    input  logic [63:0] rej_entry,
    input  logic        ev_pull_err,
    input  logic        ev_dma_bad,
    input  logic        ev_dma_fault,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        chsw_en,
    output logic        log_full,
    output logic        log_empty
);

    localparam int PW = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1;

    reg_sel_e          sel;
    logic [PW-1:0]     put_p, get_p, get_val;
    logic              accept, drop, full, empty;
    runout_rec_t       head;
    logic [DATA_W-1:0] set_vec, clr_vec, pend, mask;
    logic              sw_q;

    assign sel     = reg_sel_e'(reg_addr);
    assign get_val = PW'(reg_wdata % 32'(LOG_DEPTH));

    runout_ring #(.DEPTH(LOG_DEPTH), .PW(PW)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .push_i   (rej_valid),
        .rec_i    (runout_rec_t'(rej_entry)),
        .get_wr_i (reg_wr && sel == SEL_GET),
        .get_val_i(get_val),
        .put_o    (put_p),
        .get_o    (get_p),
        .full_o   (full),
        .empty_o  (empty),
        .accept_o (accept),
        .drop_o   (drop),
        .head_o   (head)
    );

    always_comb begin
        set_vec                = '0;
        set_vec[IRQ_PULL_ERR]  = ev_pull_err;
        set_vec[IRQ_RUNOUT]    = accept;
        set_vec[IRQ_OVERFLOW]  = drop;
        set_vec[IRQ_DMA_BAD]   = ev_dma_bad;
        set_vec[IRQ_DMA_FAULT] = ev_dma_fault;
        clr_vec = (reg_wr && sel == SEL_PEND) ? reg_wdata : '0;
    end

    runout_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .en_i      (glob_en),
        .set_i     (set_vec),
        .clr_i     (clr_vec),
        .mask_wr_i (reg_wr && sel == SEL_MASK),
        .mask_val_i(reg_wdata),
        .pend_o    (pend),
        .mask_o    (mask),
        .irq_o     (irq)
    );

    always_ff @(posedge clk) begin
        if (rst || !glob_en)                sw_q <= 1'b0;
        else if (reg_wr && sel == SEL_SWITCH) sw_q <= reg_wdata[0];
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_STATUS: reg_rdata = {30'd0, full, empty};
            SEL_PUT:    reg_rdata = 32'(put_p);
            SEL_GET:    reg_rdata = 32'(get_p);
            SEL_PEND:   reg_rdata = pend;
            SEL_MASK:   reg_rdata = mask;
            SEL_SWITCH: reg_rdata = {31'd0, sw_q};
            SEL_HEAD_L: reg_rdata = head.addr;
            SEL_HEAD_H: reg_rdata = head.data;
            default:    reg_rdata = '0;
        endcase
    end

    assign chsw_en   = sw_q;
    assign log_full  = full;
    assign log_empty = empty;

    // full and empty never hold together
    assert_flags_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(log_full && log_empty));

    // switch enable cleared while master switch was low
    assert_switch_forced_R9: assert property (@(posedge clk) disable iff (rst)
        !glob_en |=> !chsw_en);

endmodule

// File: tb/sim_runout_irq_unit.sv
module sim_runout_irq_unit;

    localparam int CLK_PERIOD = 10;
    localparam int D          = 8;
    localparam logic [31:0] VALID = 32'h0001_1111;

    logic        clk = 1'b0;
    logic        rst;
    logic        glob_en, rej_valid, ev_pull_err, ev_dma_bad, ev_dma_fault, reg_wr;
    logic [63:0] rej_entry;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        irq, chsw_en, log_full, log_empty;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [63:0] m_mem [D];
    int          m_put, m_get;
    logic [31:0] m_pend, m_mask;
    logic        m_sw, m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    runout_irq_unit #(.LOG_DEPTH(D)) u0 (
        .clk(clk), .rst(rst), .glob_en(glob_en), .rej_valid(rej_valid),
        .rej_entry(rej_entry), .ev_pull_err(ev_pull_err), .ev_dma_bad(ev_dma_bad),
        .ev_dma_fault(ev_dma_fault), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .chsw_en(chsw_en),
        .log_full(log_full), .log_empty(log_empty)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic m_full();
        return ((m_put + 1) % D) == m_get;
    endfunction

    function automatic logic [31:0] m_read(input int a);
        case (a)
            0: return {30'd0, m_full(), m_put == m_get};
            1: return 32'(m_put);
            2: return 32'(m_get);
            3: return m_pend;
            4: return m_mask;
            5: return {31'd0, m_sw};
            6: return m_mem[m_get][31:0];
            default: return m_mem[m_get][63:32];
        endcase
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0: return "R8/R10 status";
            1: return "R2/R10 put";
            2: return "R7/R10 get";
            3: return "R5/R10 pending";
            4: return "R6/R10 mask";
            5: return "R9/R10 switch";
            default: return "R7/R10 record";
        endcase
    endfunction

    // drive one cycle, compare before the edge, then advance the model
    task automatic step(input logic en, input logic rj, input logic [63:0] ent,
                        input logic pe, input logic db, input logic df,
                        input logic wr, input logic [2:0] a, input logic [31:0] wd);
        logic [31:0] clr, setv;
        logic        full_old, acc;
        glob_en = en; rej_valid = rj; rej_entry = ent;
        ev_pull_err = pe; ev_dma_bad = db; ev_dma_fault = df;
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        #1;
        chk("R6 irq", {63'd0, irq}, {63'd0, m_irq});
        chk("R8 full", {63'd0, log_full}, {63'd0, m_full()});
        chk("R8 empty", {63'd0, log_empty}, {63'd0, m_put == m_get});
        chk("R9 chsw", {63'd0, chsw_en}, {63'd0, m_sw});
        if (!(a >= 6 && m_put == m_get))
            chk(tag_of(int'(a)), {32'd0, reg_rdata}, {32'd0, m_read(int'(a))});
        @(posedge clk);
        full_old = m_full();
        acc      = rj && !full_old;
        m_irq    = |(m_pend & m_mask);
        setv     = '0;
        if (pe) setv[0]  = 1'b1;
        if (acc) setv[4] = 1'b1;
        if (rj && full_old) setv[8] = 1'b1;
        if (db) setv[12] = 1'b1;
        if (df) setv[16] = 1'b1;
        clr = (wr && a == 3'd3) ? wd : 32'd0;
        if (acc) begin
            m_mem[m_put] = ent;
            m_put = (m_put + 1) % D;
        end
        if (wr && a == 3'd2) m_get = int'(wd % 32'(D));
        m_pend = ((m_pend & ~clr) | setv) & VALID;
        if (!en) begin
            m_mask = '0;
            m_sw   = 1'b0;
        end else if (wr) begin
            if (a == 3'd4) m_mask = wd & VALID;
            if (a == 3'd5) m_sw   = wd[0];
        end
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b1, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0);
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] v);
        rej_valid = 1'b0; ev_pull_err = 1'b0; ev_dma_bad = 1'b0; ev_dma_fault = 1'b0;
        reg_wr = 1'b0; reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; glob_en = 1'b0; rej_valid = 1'b0; rej_entry = '0;
        ev_pull_err = 1'b0; ev_dma_bad = 1'b0; ev_dma_fault = 1'b0;
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        m_put = 0; m_get = 0; m_pend = '0; m_mask = '0; m_sw = 1'b0; m_irq = 1'b0;
        for (int i = 0; i < D; i++) m_mem[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 irq", {63'd0, irq}, 64'd0);
        chk("R1 empty", {63'd0, log_empty}, 64'd1);
        chk("R1 full", {63'd0, log_full}, 64'd0);
        for (int a = 1; a <= 5; a++) begin
            peek(3'(a), v);
            chk("R1 register", {32'd0, v}, 64'd0);
        end

        // R4: events latch while masked; R6: line stays low
        step(1'b1, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0);
        peek(3'd3, v); chk("R4 puller bit", {32'd0, v}, 64'h1);
        step(1'b1, 1'b0, 64'd0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 32'd0);
        peek(3'd3, v); chk("R4 dma bits", {32'd0, v}, 64'h0001_1001);
        idle();
        chk("R6 masked line", {63'd0, irq}, 64'd0);

        // R6: mask write, line follows one cycle after the mask register
        step(1'b1, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4, 32'hFFFF_FFFF);
        peek(3'd4, v); chk("R6 mask bits", {32'd0, v}, {32'd0, VALID});
        chk("R6 latency low", {63'd0, irq}, 64'd0);
        idle();
        chk("R6 latency high", {63'd0, irq}, 64'd1);

        // R5: set wins over clear in the same cycle; clear of bit 16
        step(1'b1, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd3, 32'h0000_0001);
        peek(3'd3, v); chk("R5 set beats clear", {32'd0, v}, 64'h0001_1001);
        step(1'b1, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 32'h0001_0000);
        peek(3'd3, v); chk("R5 clear one", {32'd0, v}, 64'h0000_1001);
        step(1'b1, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 32'hFFFF_FFFF);

        // R2/R3: fill the ring then overflow
        for (int i = 0; i < D - 1; i++)
            step(1'b1, 1'b1, {32'hD000_0000 + 32'(i), 32'hA000_0000 + 32'(i)},
                 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0);
        chk("R8 full after fill", {63'd0, log_full}, 64'd1);
        peek(3'd3, v); chk("R2 runout bit only", {32'd0, v}, 64'h10);
        step(1'b1, 1'b1, 64'hDEAD_BEEF_0BAD_F00D, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0);
        peek(3'd1, v); chk("R3 put held", {32'd0, v}, 64'(D - 1));
        peek(3'd3, v); chk("R3 overflow bit", {32'd0, v}, 64'h110);

        // R7: record at read pointer, pointer write wraps
        peek(3'd6, v); chk("R7 record low", {32'd0, v}, 64'hA000_0000);
        step(1'b1, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 32'(D + 3));
        peek(3'd2, v); chk("R7 wrap", {32'd0, v}, 64'd3);
        peek(3'd7, v); chk("R7 record high", {32'd0, v}, 64'hD000_0003);

        // R9: master switch low forces mask and switch enable
        step(1'b1, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd5, 32'd1);
        chk("R9 switch set", {63'd0, chsw_en}, 64'd1);
        step(1'b0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd5, 32'd1);
        chk("R9 switch forced", {63'd0, chsw_en}, 64'd0);
        peek(3'd4, v); chk("R9 mask forced", {32'd0, v}, 64'd0);

        // random collisions of events, rejects and register writes
        for (int n = 0; n < 6000; n++) begin
            logic en;
            logic [2:0] a;
            en = ((n / 300) % 4) != 3;
            a  = 3'($urandom_range(0, 7));
            step(en, ($urandom_range(0, 9) < 4), {$urandom, $urandom},
                 ($urandom_range(0, 19) == 0), ($urandom_range(0, 29) == 0),
                 ($urandom_range(0, 29) == 0), ($urandom_range(0, 9) < 3), a,
                 (a == 3'd2 || a == 3'd5) ? $urandom : ($urandom & VALID));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule